// File: doc/BRIEF.md
# Triple-Redundant State Stage with Majority Vote and Halt

This block runs one wide state vector through three identical copies of a combinational transform at once and merges the three results with a bitwise two-of-three vote. When at least two of the three result vectors match in full, the voted vector is captured in an output register and a one-cycle ready strobe tells the next stage that it may take and re-encode the value. A per-replica flag reports which copy, if any, disagreed with the vote. When all three result vectors differ from one another, the block does not trust any of them. It raises a stop flag, holds the output register, and ignores all further work until reset.

The transform is a placeholder: each output bit is the input bit XOR-ed with the input rotated left by `ROT` positions, so `y[i] = x[i] ^ x[(i - ROT) mod W]`. Each replica also has its own fault-injection mask, which is XOR-ed onto that replica's result. This lets a test corrupt any set of bits in any replica.

Top module: `tmr_vote_stage`

## Requirements
- R1: While reset is active and on the first cycle after it, `state_out` is all zero and `ready`, `stop` and `mismatch` are all low.
- R2: With all injection masks zero, a cycle with `en` high and `stop` low gives `state_out[i] = state_in[i] ^ state_in[(i - ROT) mod W]` after the next rising clock edge. The rotation wraps bit W-1 into bit ROT-1.
- R3: `ready` is high for exactly the one cycle after an accepted enable. In a cycle with no accepted enable, `state_out` keeps its previous value.
- R4: Any number of corrupted bits confined to one replica is fully masked: `state_out` equals the clean transform. `mismatch[k]` is set for the corrupted replica k (bit 0 = replica 0, bit 1 = replica 1, bit 2 = replica 2), and only that bit is set.
- R5: When all three replica results are identical, `mismatch` is 3'b000 on the ready cycle.
- R6: When two replicas carry the same corruption and the third is clean, the matching pair wins. `state_out` equals the corrupted pair's value and the mismatch bit of the clean replica is set.
- R7: When the three replica results differ pairwise on an accepted enable, `stop` goes high after the next edge, `ready` stays low in that cycle, `state_out` keeps its previous value, and `mismatch` becomes 3'b111.
- R8: The halt of R7 happens even when every single bit still has a two-of-three majority, for example when each replica is corrupted in different bit positions.
- R9: Once high, `stop` stays high until reset. While it is high, `en` is ignored: `ready` stays low and `state_out` and `mismatch` do not change.
- R10: Asserting reset clears `stop`, and accepted enables are processed normally afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Process `state_in` in this cycle |
| state_in | input | W | State vector fed to all three replicas |
| inj0 | input | W | Fault mask XOR-ed onto replica 0's result |
| inj1 | input | W | Fault mask XOR-ed onto replica 1's result |
| inj2 | input | W | Fault mask XOR-ed onto replica 2's result |
| state_out | output | W | Registered voted vector |
| ready | output | 1 | One-cycle strobe: `state_out` holds a new voted vector |
| stop | output | 1 | Sticky halt: no two replicas agreed |
| mismatch | output | 3 | Per-replica disagreement with the vote, or all ones after a halt |

## Verification
A wrong vote or a swapped replica index would show at the ports one edge after the enable: `state_out` would carry corrupted bits, or the wrong `mismatch` bit would be set on the ready cycle. A faulty agreement classifier is exposed by vectors that differ pairwise while every bit still has a majority. Such a classifier would produce a ready strobe where `stop` should rise. A stop register that is not sticky, or that does not gate `en`, would show on the first enable after the halt as a fresh ready pulse or a changed `state_out`.

// File: rtl/tmr_vote_pkg.sv
package tmr_vote_pkg;

  // Classification of the three replica results
  typedef enum logic [1:0] {
    VERDICT_UNANIMOUS = 2'd0,  // all three identical
    VERDICT_OUTVOTED  = 2'd1,  // exactly one pair matches
    VERDICT_SPLIT     = 2'd2   // pairwise distinct, no trustworthy value
  } verdict_e;

endpackage

// File: rtl/tmr_replica.sv
module tmr_replica #(
  parameter int W   = 1600,
  parameter int ROT = 3
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] flip_mask,
  output logic [W-1:0] y
);

  localparam int ROT_M = ROT % W;

  // Placeholder state transform: XOR with a left rotation of itself
  function automatic logic [W-1:0] xform(input logic [W-1:0] v);
    logic [W-1:0] rotated;
    rotated = (v << ROT_M) | (v >> (W - ROT_M));
    return v ^ rotated;
  endfunction

  assign y = xform(x) ^ flip_mask;

endmodule

// File: rtl/tmr_voter.sv
module tmr_voter
  import tmr_vote_pkg::*;
#(
  parameter int W = 1600
) (
  input  logic [W-1:0] rep_a,
  input  logic [W-1:0] rep_b,
  input  logic [W-1:0] rep_c,
  output logic [W-1:0] voted,
  output verdict_e     verdict,
  output logic [2:0]   dissent
);

  // Two-of-three majority per bit: three ANDs feeding two ORs
  function automatic logic [W-1:0] maj3(input logic [W-1:0] a,
                                        input logic [W-1:0] b,
                                        input logic [W-1:0] c);
    return (a & b) | (b & c) | (a & c);
  endfunction

  logic eq_ab, eq_bc, eq_ac;

  assign voted = maj3(rep_a, rep_b, rep_c);
  assign eq_ab = (rep_a == rep_b);
  assign eq_bc = (rep_b == rep_c);
  assign eq_ac = (rep_a == rep_c);

  always_comb begin
    if (eq_ab && eq_bc)              verdict = VERDICT_UNANIMOUS;
    else if (eq_ab || eq_bc || eq_ac) verdict = VERDICT_OUTVOTED;
    else                              verdict = VERDICT_SPLIT;
  end

  assign dissent[0] = (rep_a != voted);
  assign dissent[1] = (rep_b != voted);
  assign dissent[2] = (rep_c != voted);

endmodule

// File: rtl/tmr_stage_reg.sv
module tmr_stage_reg
  import tmr_vote_pkg::*;
#(
  parameter int W = 1600
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  verdict_e     verdict,
  input  logic [W-1:0] voted,
  input  logic [2:0]   dissent,
  output logic [W-1:0] q,
  output logic         strobe,
  output logic         halted,
  output logic [2:0]   flags
);

  logic accept;
  logic split;

  assign accept = take && !halted;
  assign split  = (verdict == VERDICT_SPLIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q      <= '0;
      strobe <= 1'b0;
      halted <= 1'b0;
      flags  <= 3'b000;
    end else begin
      strobe <= 1'b0;
      if (accept) begin
        if (split) begin
          halted <= 1'b1;
          flags  <= 3'b111;
        end else begin
          q      <= voted;
          strobe <= 1'b1;
          flags  <= dissent;
        end
      end
    end
  end

endmodule

// File: rtl/tmr_vote_stage.sv
module tmr_vote_stage
  import tmr_vote_pkg::*;
#(
  parameter int W   = 1600,
  parameter int ROT = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] state_in,
  input  logic [W-1:0] inj0,
  input  logic [W-1:0] inj1,
  input  logic [W-1:0] inj2,
  output logic [W-1:0] state_out,
  output logic         ready,
  output logic         stop,
  output logic [2:0]   mismatch
);

  localparam int NREP = 3;

  logic [W-1:0] inj_v [NREP];
  logic [W-1:0] rep_v [NREP];

  // Named internal events for the checker
  logic [W-1:0] rep0, rep1, rep2;
  logic [W-1:0] voted;
  verdict_e     verdict;
  logic [2:0]   dissent;

  assign inj_v[0] = inj0;
  assign inj_v[1] = inj1;
  assign inj_v[2] = inj2;

  for (genvar k = 0; k < NREP; k++) begin : g_rep
    tmr_replica #(.W(W), .ROT(ROT)) u_rep (
      .x         (state_in),
      .flip_mask (inj_v[k]),
      .y         (rep_v[k])
    );
  end

  assign rep0 = rep_v[0];
  assign rep1 = rep_v[1];
  assign rep2 = rep_v[2];

  tmr_voter #(.W(W)) u_voter (
    .rep_a   (rep0),
    .rep_b   (rep1),
    .rep_c   (rep2),
    .voted   (voted),
    .verdict (verdict),
    .dissent (dissent)
  );

  tmr_stage_reg #(.W(W)) u_reg (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (en),
    .verdict (verdict),
    .voted   (voted),
    .dissent (dissent),
    .q       (state_out),
    .strobe  (ready),
    .halted  (stop),
    .flags   (mismatch)
  );

endmodule

// File: rtl/tmr_vote_chk.sv
module tmr_vote_chk #(
  parameter int W = 1600
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         ready,
  input logic         stop,
  input logic [2:0]   mismatch,
  input logic [W-1:0] state_out,
  input logic [W-1:0] rep0,
  input logic [W-1:0] rep1,
  input logic [W-1:0] rep2,
  input logic [W-1:0] voted
);

  // R9
  stop_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> stop);

  // R7
  stop_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop |-> !ready);

  // R3
  ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $past(en));

  // R3
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> $stable(state_out));

  // R4
  single_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> $onehot0(mismatch));

  // R6
  pair_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((rep0 == rep1) || (rep0 == rep2)) |-> (voted == rep0));

  // R7
  split_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !stop && (rep0 != rep1) && (rep1 != rep2) && (rep0 != rep2))
      |=> (stop && !ready && mismatch == 3'b111));

endmodule

bind tmr_vote_stage tmr_vote_chk #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .en        (en),
  .ready     (ready),
  .stop      (stop),
  .mismatch  (mismatch),
  .state_out (state_out),
  .rep0      (rep0),
  .rep1      (rep1),
  .rep2      (rep2),
  .voted     (voted)
);

// File: tb/tb_tmr_vote_stage.sv
`timescale 1ns/1ps
module tb_tmr_vote_stage;

  localparam int W   = 1600;
  localparam int ROT = 3;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en;
  logic [W-1:0] state_in, inj0, inj1, inj2;
  logic [W-1:0] state_out;
  logic         ready, stop;
  logic [2:0]   mismatch;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tmr_vote_stage #(.W(W), .ROT(ROT)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .state_in(state_in),
    .inj0(inj0), .inj1(inj1), .inj2(inj2),
    .state_out(state_out), .ready(ready), .stop(stop), .mismatch(mismatch)
  );

  // Bit-by-bit restatement of the transform
  function automatic logic [W-1:0] model(input logic [W-1:0] v);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = v[i] ^ v[(i + W - ROT) % W];
    return r;
  endfunction

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic [2:0] act, input logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic chk_vec(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual[63:0]=%h expected[63:0]=%h", req, act[63:0], exp[63:0]);
    end
  endtask

  // Drive one enable cycle; returns at the negedge after the capturing edge
  task automatic fire(input logic [W-1:0] x, input logic [W-1:0] m0,
                      input logic [W-1:0] m1, input logic [W-1:0] m2);
    @(negedge clk);
    en = 1'b1; state_in = x; inj0 = m0; inj1 = m1; inj2 = m2;
    @(negedge clk);
    en = 1'b0; inj0 = '0; inj1 = '0; inj2 = '0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; en = 1'b0; state_in = '0; inj0 = '0; inj1 = '0; inj2 = '0;
    repeat (3) @(negedge clk);
    chk_vec ("R1 out in reset", state_out, '0);
    chk_bit ("R1 ready in reset", ready, 1'b0);
    chk_bit ("R1 stop in reset", stop, 1'b0);
    chk_flags("R1 mismatch in reset", mismatch, 3'b000);
    rst_n = 1'b1;
    @(negedge clk);
    chk_bit ("R1 ready after reset", ready, 1'b0);
    chk_vec ("R1 out after reset", state_out, '0);
  endtask

  task automatic t_clean(input logic [W-1:0] x, input string tag);
    fire(x, '0, '0, '0);
    chk_vec  ({"R2 clean ", tag}, state_out, model(x));
    chk_bit  ({"R3 ready ", tag}, ready, 1'b1);
    chk_flags({"R5 unanimous ", tag}, mismatch, 3'b000);
  endtask

  task automatic t_hold();
    logic [W-1:0] prev;
    prev = state_out;
    @(negedge clk);
    chk_bit("R3 ready one cycle", ready, 1'b0);
    state_in = ~state_in;
    @(negedge clk);
    chk_vec("R3 out holds without en", state_out, prev);
  endtask

  task automatic t_single(input int k, input logic [W-1:0] x, input logic [W-1:0] m);
    logic [2:0] exp_f;
    exp_f = 3'b001 << k;
    fire(x, (k == 0) ? m : '0, (k == 1) ? m : '0, (k == 2) ? m : '0);
    chk_vec  ("R4 single replica masked", state_out, model(x));
    chk_flags("R4 flag names replica", mismatch, exp_f);
    chk_bit  ("R4 ready", ready, 1'b1);
  endtask

  task automatic t_pair_wins(input logic [W-1:0] x, input logic [W-1:0] m);
    fire(x, m, m, '0);
    chk_vec  ("R6 matching pair wins", state_out, model(x) ^ m);
    chk_flags("R6 clean replica flagged", mismatch, 3'b100);
  endtask

  task automatic t_split(input logic [W-1:0] x, input logic [W-1:0] m0,
                         input logic [W-1:0] m1, input logic [W-1:0] m2, input string req);
    logic [W-1:0] prev;
    prev = state_out;
    fire(x, m0, m1, m2);
    chk_bit  ({req, " stop raised"}, stop, 1'b1);
    chk_bit  ({req, " no ready"}, ready, 1'b0);
    chk_vec  ({req, " out held"}, state_out, prev);
    chk_flags({req, " mismatch all"}, mismatch, 3'b111);
  endtask

  task automatic t_sticky(input logic [W-1:0] x);
    logic [W-1:0] prev;
    prev = state_out;
    fire(x, '0, '0, '0);
    chk_bit  ("R9 stop stays", stop, 1'b1);
    chk_bit  ("R9 en ignored no ready", ready, 1'b0);
    chk_vec  ("R9 out unchanged", state_out, prev);
    chk_flags("R9 mismatch unchanged", mismatch, 3'b111);
    repeat (3) @(negedge clk);
    chk_bit  ("R9 stop still high", stop, 1'b1);
  endtask

  task automatic t_resume(input logic [W-1:0] x);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk_bit("R10 reset clears stop", stop, 1'b0);
    rst_n = 1'b1;
    fire(x, '0, '0, '0);
    chk_vec("R10 resumes", state_out, model(x));
    chk_bit("R10 ready after resume", ready, 1'b1);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [W-1:0] p1, p2, p3, p4, mA, mB, mC;
    p1 = {50{32'h0123_4567}};
    p2 = {25{64'hFEDC_BA98_7654_3210}};
    p3 = {W{1'b1}};
    p4 = '0; p4[W-1] = 1'b1;          // wrap boundary
    mA = {50{32'hFFFF_0000}};         // many bits in one replica
    mB = '0; mB[0] = 1'b1;
    mC = '0; mC[W-1] = 1'b1;

    t_reset();
    t_clean(p1, "p1");
    t_hold();
    t_clean(p2, "p2");
    t_clean(p3, "all ones");
    t_clean(p4, "top bit wrap");
    t_single(0, p1, mA);
    t_single(1, p2, mB);
    t_single(2, p4, mC);
    t_pair_wins(p2, mA);
    t_split(p1, '0, mB, mC, "R8 disjoint bits");
    t_sticky(p2);
    t_resume(p1);
    t_split(p2, mA, mB, mC, "R7 pairwise distinct");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule